// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target is holding stuck, with SDA pulled low, after a transfer was cut off part way. While SDA stays released it clocks SCL through nine full low/high pulses. It then builds a STOP condition by hand and samples SDA once more to report whether the bus is free. It drives the two bus lines through open-drain pull enables: a 1 pulls the line low and a 0 releases it. It reads the resolved level of SDA back from the pad.

A sequence starts in one of two ways. Software can pulse the start strobe. The block can also start on its own after the master enable rises, if SDA is still low when a fixed watch window ends. The length of one bus half-period is set in system clock cycles by an input word. That word is captured when a sequence starts. While a sequence runs, a busy flag is high. At the end a one-cycle done pulse comes with a pass/fail verdict. A controller that sees a fail verdict treats the bus as busy and aborts the transfer it had pending.

Top module: `i2c_bus_recover`

## Requirements
- R1: While reset is held and in the first cycle after it, scl_pull, sda_pull, busy, done and ok are all 0.
- R2: A start pulse sampled at a clock edge while idle makes busy rise after that edge. busy stays high until the cycle after done. While idle, neither line is pulled. A start pulse while busy is ignored.
- R3: A sequence opens with 2*PULSES phases (PULSES=9). Even phases pull SCL and odd phases release it, so SCL makes nine full pulses while SDA stays released.
- R4: Every phase lasts N cycles. N is the half_period value captured at the start sample, and a captured value of 0 means N=1. Changes to half_period during a sequence have no effect.
- R5: Four STOP phases follow the pulses, N cycles each, in this order: SCL pulled with SDA released, then both pulled, then SDA pulled with SCL released, then both released.
- R6: At the clock edge that ends the last STOP phase, ok takes the sampled value of sda_in and done is high for exactly one cycle. ok clears to 0 when a new sequence starts and otherwise holds its value.
- R7: When enable is sampled high after being low, a window of WATCH_CYCLES edges begins. If sda_in is low at the edge that closes the window, a sequence starts one cycle later, exactly as if start had been pulsed. If sda_in is high at that edge, nothing starts.
- R8: If enable drops before the window closes, the window is cancelled. Each rise of enable opens at most one window.
- R9: sda_pull only becomes 1 while scl_pull is 1 and was already 1 in the previous cycle, so the block never creates a START condition by accident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Master enable; its rising edge opens the stuck-SDA watch window |
| start | input | 1 | One-cycle strobe requesting a recovery sequence |
| half_period | input | HP_W | Bus half-period in clock cycles (0 is treated as 1) |
| sda_in | input | 1 | Resolved SDA level read from the pad |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| busy | output | 1 | High while a sequence runs, through its done cycle |
| done | output | 1 | One-cycle pulse when the sequence ends |
| ok | output | 1 | Verdict: 1 when SDA was found high at the end |

## Verification
The checker watches several rules on every cycle. SDA is never pulled unless SCL has been low for at least one full cycle. Nothing is driven while idle. done is a single-cycle pulse inside busy. Every rise of busy follows a start request or an automatic trigger. ok changes only when a sequence opens or closes.

Some behaviour only the bench scenarios can show. These are the exact phase lengths, including the zero-means-one case and a half_period change made mid-run. They also include the count of nine pulses, the order of the STOP steps, and the verdict against a target that lets go of SDA versus one that never does. The last group is the watch window: whether it fires, stays quiet or is cancelled, compared cycle by cycle against a behavioural model.

// File: rtl/i2c_rcv_pkg.sv
// Package: shared types for the I2C bus recovery sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_rcv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rcv_state_t;
endpackage

// File: rtl/i2c_rcv_halfper.sv
// Module: half-period timer. Latches the period on load and issues a tick
// on the last cycle of every phase while run_en is high.
// Assumes: load only arrives while run_en is low.
module i2c_rcv_halfper #(
    parameter int HP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [HP_W-1:0] half_period,
    input  logic            run_en,
    output logic            tick
);
    logic [HP_W-1:0] n_lat;
    logic [HP_W-1:0] cnt;

    // Capture the phase length at load, mapping 0 to 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            n_lat <= HP_W'(1);
        else if (load)
            n_lat <= (half_period == '0) ? HP_W'(1) : half_period;
    end

    // Count cycles inside a phase; wrap on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Tick on the final cycle of the phase.
    assign tick = run_en && (cnt == n_lat - 1'b1);
endmodule

// File: rtl/i2c_rcv_watch.sv
// Module: stuck-SDA watcher. On a rising enable it counts WATCH_CYCLES edges
// and then issues a one-cycle trigger if SDA is low at the closing edge.
// Assumes: WATCH_CYCLES >= 1.
module i2c_rcv_watch #(
    parameter int WATCH_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sda_in,
    output logic fire
);
    localparam int WC_W = $clog2(WATCH_CYCLES + 1);
    localparam logic [WC_W-1:0] WLAST = WC_W'(WATCH_CYCLES - 1);

    logic            en_q;
    logic            armed;
    logic [WC_W-1:0] wcnt;

    // Track enable, run the window, and emit the trigger pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            armed <= 1'b0;
            wcnt  <= '0;
            fire  <= 1'b0;
        end else begin
            en_q <= enable;
            fire <= 1'b0;
            if (!enable) begin
                armed <= 1'b0;
            end else if (!en_q) begin
                armed <= 1'b1;
                wcnt  <= '0;
            end else if (armed) begin
                if (wcnt == WLAST) begin
                    armed <= 1'b0;
                    fire  <= ~sda_in;
                end else begin
                    wcnt <= wcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_rcv_fsm.sv
// Module: recovery phase sequencer. Steps through the clock pulses and the
// STOP phases on timer ticks and decodes the open-drain pulls from the phase.
// Assumes: tick is high only on the last cycle of a phase.
module i2c_rcv_fsm
    import i2c_rcv_pkg::*;
#(
    parameter int PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic tick,
    input  logic sda_in,
    output logic load,
    output logic run_en,
    output logic scl_pull,
    output logic sda_pull,
    output logic busy,
    output logic done,
    output logic ok
);
    localparam int NPH  = 2 * PULSES + 4;
    localparam int PH_W = $clog2(NPH);
    localparam logic [PH_W-1:0] PH_STOP0 = PH_W'(2 * PULSES);
    localparam logic [PH_W-1:0] PH_STOP1 = PH_W'(2 * PULSES + 1);
    localparam logic [PH_W-1:0] PH_STOP2 = PH_W'(2 * PULSES + 2);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(NPH - 1);

    rcv_state_t      state;
    logic [PH_W-1:0] ph;

    assign load   = (state == ST_IDLE) && go;
    assign run_en = (state == ST_RUN);
    assign busy   = (state != ST_IDLE);
    assign done   = (state == ST_DONE);

    // Advance state and phase; sample the verdict at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ph    <= '0;
            ok    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (go) begin
                    state <= ST_RUN;
                    ph    <= '0;
                    ok    <= 1'b0;
                end
                ST_RUN: if (tick) begin
                    if (ph == PH_LAST) begin
                        state <= ST_DONE;
                        ok    <= sda_in;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the line pulls from the current phase.
    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        if (state == ST_RUN) begin
            if (ph < PH_STOP0) begin
                scl_pull = ~ph[0];
            end else if (ph == PH_STOP0) begin
                scl_pull = 1'b1;
            end else if (ph == PH_STOP1) begin
                scl_pull = 1'b1;
                sda_pull = 1'b1;
            end else if (ph == PH_STOP2) begin
                sda_pull = 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_bus_recover.sv
// Module: top of the I2C bus recovery sequencer. Joins the stuck-SDA
// watcher, the half-period timer and the phase sequencer.
// Assumes: sda_in is already synchronised to clk.
module i2c_bus_recover #(
    parameter int HP_W         = 16,
    parameter int PULSES       = 9,
    parameter int WATCH_CYCLES = 250000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            start,
    input  logic [HP_W-1:0] half_period,
    input  logic            sda_in,
    output logic            scl_pull,
    output logic            sda_pull,
    output logic            busy,
    output logic            done,
    output logic            ok
);
    logic auto_go;
    logic load;
    logic run_en;
    logic tick;

    i2c_rcv_watch #(.WATCH_CYCLES(WATCH_CYCLES)) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .sda_in (sda_in),
        .fire   (auto_go)
    );

    i2c_rcv_halfper #(.HP_W(HP_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .half_period (half_period),
        .run_en      (run_en),
        .tick        (tick)
    );

    i2c_rcv_fsm #(.PULSES(PULSES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (start | auto_go),
        .tick     (tick),
        .sda_in   (sda_in),
        .load     (load),
        .run_en   (run_en),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull),
        .busy     (busy),
        .done     (done),
        .ok       (ok)
    );
endmodule

// File: rtl/i2c_bus_recover_chk.sv
// Module: assertion checker bound to i2c_bus_recover.
// Assumes: synchronous active-low reset.
module i2c_bus_recover_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic auto_go,
    input logic scl_pull,
    input logic sda_pull,
    input logic busy,
    input logic done,
    input logic ok
);
    // R9
    sda_pull_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> (scl_pull && $past(scl_pull)));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_pull && !sda_pull && !done));
    // R2
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start || auto_go));
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && $past(busy)));
    // R6
    ok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$rose(busy) && !done) |-> $stable(ok));
endmodule

bind i2c_bus_recover i2c_bus_recover_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .auto_go  (auto_go),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .busy     (busy),
    .done     (done),
    .ok       (ok)
);

// File: tb/tb_i2c_bus_recover.sv
// Bench: behavioural reference model compared on every clock, plus
// scenario checks for pulse count, verdict and the watch window.
module tb_i2c_bus_recover;
    localparam int HP_W  = 16;
    localparam int WATCH = 40;
    localparam int NPH   = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic start = 1'b0;
    logic [HP_W-1:0] half_period = '0;
    logic sda_in;
    logic scl_pull, sda_pull, busy, done, ok;

    // target model: holds SDA low until hold_n SCL releases are seen
    logic hold = 1'b0;
    int   hold_n = 0;
    int   rel_cnt = 0;
    int   bad_sda = 0;
    logic p_scl = 1'b0;
    logic p_sda = 1'b0;

    int errors = 0;
    int checks = 0;

    assign sda_in = ~sda_pull & ~hold;

    always #4 clk = ~clk;

    i2c_bus_recover #(.HP_W(HP_W), .PULSES(9), .WATCH_CYCLES(WATCH)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .half_period(half_period), .sda_in(sda_in), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .busy(busy), .done(done), .ok(ok)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model state
    int   m_state = 0;
    int   m_t = 0;
    int   m_n = 1;
    logic m_ok = 1'b0;
    logic m_enq = 1'b0;
    int   m_wleft = -1;
    logic m_fire = 1'b0;
    bit   cmp_on = 1'b0;

    // Model update at the clock edge from bench-driven inputs.
    always @(posedge clk) begin
        logic g;
        if (!rst_n) begin
            m_state = 0; m_ok = 1'b0; m_enq = 1'b0; m_wleft = -1; m_fire = 1'b0;
        end else begin
            g = start || m_fire;
            m_fire = 1'b0;
            if (!enable) m_wleft = -1;
            else if (!m_enq) m_wleft = WATCH;
            else if (m_wleft > 0) begin
                m_wleft--;
                if (m_wleft == 0) begin m_fire = !sda_in; m_wleft = -1; end
            end
            m_enq = enable;
            if (m_state == 0) begin
                if (g) begin
                    m_state = 1; m_t = 0; m_ok = 1'b0;
                    m_n = (half_period == 0) ? 1 : int'(half_period);
                end
            end else if (m_state == 1) begin
                m_t++;
                if (m_t == NPH * m_n) begin m_state = 2; m_ok = sda_in; end
            end else m_state = 0;
        end
    end

    // Compare every cycle and run the target model away from the edge.
    always @(negedge clk) begin
        int ph;
        logic e_scl, e_sda;
        ph = m_t / m_n;
        e_scl = (m_state == 1) && ((ph < 18) ? (ph % 2 == 0) : (ph <= 19));
        e_sda = (m_state == 1) && (ph == 19 || ph == 20);
        if (cmp_on) begin
            chk("R3 scl_pull", scl_pull, e_scl);
            chk("R5 sda_pull", sda_pull, e_sda);
            chk("R2 busy", busy, m_state != 0);
            chk("R6 done", done, m_state == 2);
            chk("R6 ok", ok, m_ok);
        end
        if (sda_pull && !p_sda && !(scl_pull && p_scl)) bad_sda++;
        if (p_scl && !scl_pull && !sda_pull) rel_cnt++;
        if (rel_cnt >= hold_n) hold = 1'b0;
        p_scl = scl_pull;
        p_sda = sda_pull;
    end

    task automatic setup_target(input int n, input logic h);
        rel_cnt = 0;
        hold_n = n;
        hold = h;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) return;
        end
        chk("R6 done never seen", 1'b0, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 scl", scl_pull, 1'b0);
        chk("R1 sda", sda_pull, 1'b0);
        chk("R1 busy", busy, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", done, 1'b0);
        chk("R1 ok", ok, 1'b0);
        cmp_on = 1'b1;

        // R3/R6: N=3, target lets go after 4 pulses -> ok=1
        half_period = 16'd3;
        setup_target(4, 1'b1);
        pulse_start();
        wait_done();
        chk_int("R3 full pulses", rel_cnt, 9);
        chk("R6 verdict pass", ok, 1'b1);
        repeat (3) @(negedge clk);

        // R2: start while busy ignored; R4: half_period change mid-run
        half_period = 16'd2;
        setup_target(0, 1'b0);
        pulse_start();
        repeat (5) @(negedge clk);
        half_period = 16'd7;
        pulse_start();
        wait_done();
        @(negedge clk);
        @(negedge clk);
        chk("R2 no restart after busy", busy, 1'b0);

        // R4: zero means one; target never lets go -> ok=0
        half_period = 16'd0;
        setup_target(99, 1'b1);
        pulse_start();
        wait_done();
        chk("R6 verdict fail", ok, 1'b0);
        chk_int("R4 nine pulses at N=1", rel_cnt, 9);
        repeat (4) @(negedge clk);
        chk("R6 ok held", ok, 1'b0);

        // R7: enable with SDA stuck low triggers automatically
        half_period = 16'd2;
        setup_target(2, 1'b1);
        @(negedge clk); enable = 1'b1;
        repeat (WATCH + 3) @(negedge clk);
        chk("R7 auto trigger", busy, 1'b1);
        wait_done();
        chk("R7 auto verdict", ok, 1'b1);
        enable = 1'b0;
        repeat (3) @(negedge clk);

        // R7: enable with SDA high does not trigger
        setup_target(0, 1'b0);
        enable = 1'b1;
        repeat (WATCH + 6) @(negedge clk);
        chk("R7 no trigger when free", busy, 1'b0);
        enable = 1'b0;
        repeat (2) @(negedge clk);

        // R8: enable dropped inside window cancels it
        setup_target(99, 1'b1);
        enable = 1'b1;
        repeat (10) @(negedge clk);
        enable = 1'b0;
        repeat (WATCH + 6) @(negedge clk);
        chk("R8 cancelled window", busy, 1'b0);
        // R8: single rise fires once only
        enable = 1'b1;
        setup_target(99, 1'b1);
        repeat (WATCH + 3) @(negedge clk);
        chk("R8 fires on rise", busy, 1'b1);
        wait_done();
        repeat (WATCH + 6) @(negedge clk);
        chk("R8 no second trigger", busy, 1'b0);
        enable = 1'b0;
        hold = 1'b0;

        // R9: SDA never pulled without SCL held low
        chk_int("R9 unsafe sda pulls", bad_sda, 0);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule